// File: doc/BRIEF.md
# USB Host Interrupt Status and Enable Bank

This block keeps the interrupt state of a USB host controller behind a small 32-bit register bus. Hardware event strobes from the controller's engines set sticky status bits, and software acknowledges each event by writing a one to its status bit. A mask of enable bits decides which pending events reach the single interrupt line.

The mask has two write addresses. Ones written to the set address turn mask bits on. Ones written to the clear address turn them off. Both addresses read back the same mask, so software never needs a read-modify-write to change one bit. Mask bit 31 is a global gate: while it is low the interrupt line stays low, whatever is pending.

The read path is combinational from the address. Writes, events and the interrupt output act on the next rising clock edge.

Top module: `usbh_irq_bank`

## Requirements
- R1: After synchronous reset, status reads 0, the mask reads 0 at both mask addresses, and `irq` is 0.
- R2: A one on `hw_evt[i]` sets status bit i at the next rising edge for each implemented source position i. The implemented positions are 0 (schedule overrun), 1 (done list written back), 2 (frame start), 3 (resume seen), 4 (fatal error), 5 (frame counter wrap), 6 (root port change) and 30 (ownership handover). Event inputs at any other position are ignored.
- R3: A bus write to the status address (offset 0x00) clears each status bit whose data bit is 1. Data bits that are 0 leave the status unchanged.
- R4: When an event and a software clear hit the same status bit in the same cycle, the bit ends up set.
- R5: A write to the mask-set address (offset 0x04) sets each mask bit whose data bit is 1. A write to the mask-clear address (offset 0x08) clears each mask bit whose data bit is 1. Zero data bits change nothing, and the mask changes only on such writes.
- R6: Reads of offset 0x04 and offset 0x08 both return the current mask.
- R7: Status bits outside the implemented positions, and mask bits outside those positions plus bit 31, always read 0 and ignore writes.
- R8: `irq` is 1 exactly when mask bit 31 is 1 and some status bit in positions 0 to 30 is set with its mask bit also set.
- R9: With mask bit 31 at 0, `irq` stays 0. A pending status bit whose own mask bit is 0 does not raise `irq`.
- R10: Reads of any other address return 0, and writes to any other address change neither the status nor the mask.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | ADDR_W (8) | Register byte address |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| hw_evt | input | 32 | Event strobes, one per status position |
| irq | output | 1 | Interrupt request |

## Verification
An event strobe and a software acknowledge can land on the same status bit in the same cycle. The bench provokes this by filling every source and then writing all ones to the status address while it strobes one source. It checks on readback that only the strobed bit survives. The mask update and the interrupt line also meet in one cycle: the bench steps the source mask and the global gate through all four combinations for every source, and compares `irq` against a value computed from its own model of status and mask.

// File: rtl/irq_bank_pkg.sv
package irq_bank_pkg;

    localparam int unsigned REG_W      = 32;
    localparam int unsigned MASTER_POS = 31;

    typedef logic [REG_W-1:0] word_t;

    // Positions that carry a real event source.
    localparam word_t EVT_SRC_MASK = 32'h4000_007F;

    typedef enum logic [1:0] {
        SEL_NONE,
        SEL_STS,
        SEL_ENA,
        SEL_DIS
    } reg_sel_e;

    typedef struct packed {
        reg_sel_e sel;
        logic     wr;
        word_t    data;
    } bus_req_t;

    // Sticky status: a set in the same cycle beats a clear.
    function automatic logic sts_bit_next(logic cur, logic set, logic clr);
        return set | (cur & ~clr);
    endfunction

    function automatic logic en_bit_next(logic cur, logic on, logic off);
        return (cur | on) & ~off;
    endfunction

endpackage

// File: rtl/irq_bank_decode.sv
module irq_bank_decode
    import irq_bank_pkg::*;
#(
    parameter int unsigned ADDR_W  = 8,
    parameter int unsigned OFS_STS = 'h00,
    parameter int unsigned OFS_ENA = 'h04,
    parameter int unsigned OFS_DIS = 'h08
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr,
    input  word_t             wdata,
    output bus_req_t          req
);

    localparam logic [ADDR_W-1:0] A_STS = ADDR_W'(OFS_STS);
    localparam logic [ADDR_W-1:0] A_ENA = ADDR_W'(OFS_ENA);
    localparam logic [ADDR_W-1:0] A_DIS = ADDR_W'(OFS_DIS);

    always_comb begin
        req.wr   = wr;
        req.data = wdata;
        if (addr == A_STS)      req.sel = SEL_STS;
        else if (addr == A_ENA) req.sel = SEL_ENA;
        else if (addr == A_DIS) req.sel = SEL_DIS;
        else                    req.sel = SEL_NONE;
    end

endmodule

// File: rtl/irq_bank_status.sv
module irq_bank_status
    import irq_bank_pkg::*;
#(
    parameter word_t EVT_MASK = EVT_SRC_MASK
) (
    input  logic     clk,
    input  logic     rst,
    input  bus_req_t req,
    input  word_t    evt,
    output word_t    sts_q
);

    logic clr_cycle;
    assign clr_cycle = req.wr && (req.sel == SEL_STS);

    for (genvar i = 0; i < REG_W; i++) begin : g_bit
        if (EVT_MASK[i]) begin : g_live
            logic bit_q;
            always_ff @(posedge clk) begin
                if (rst) bit_q <= 1'b0;
                else     bit_q <= sts_bit_next(bit_q, evt[i], clr_cycle & req.data[i]);
            end
            assign sts_q[i] = bit_q;
        end else begin : g_tied
            assign sts_q[i] = 1'b0;
        end
    end

endmodule

// File: rtl/irq_bank_enable.sv
module irq_bank_enable
    import irq_bank_pkg::*;
#(
    parameter word_t EN_MASK = EVT_SRC_MASK | (word_t'(1) << MASTER_POS)
) (
    input  logic     clk,
    input  logic     rst,
    input  bus_req_t req,
    output word_t    en_q
);

    logic set_cycle, clr_cycle;
    assign set_cycle = req.wr && (req.sel == SEL_ENA);
    assign clr_cycle = req.wr && (req.sel == SEL_DIS);

    for (genvar i = 0; i < REG_W; i++) begin : g_bit
        if (EN_MASK[i]) begin : g_live
            logic bit_q;
            always_ff @(posedge clk) begin
                if (rst) bit_q <= 1'b0;
                else     bit_q <= en_bit_next(bit_q, set_cycle & req.data[i],
                                              clr_cycle & req.data[i]);
            end
            assign en_q[i] = bit_q;
        end else begin : g_tied
            assign en_q[i] = 1'b0;
        end
    end

endmodule

// File: rtl/irq_bank_combine.sv
module irq_bank_combine
    import irq_bank_pkg::*;
(
    input  word_t sts,
    input  word_t en,
    output logic  irq
);

    localparam word_t SRC_ONLY = ~(word_t'(1) << MASTER_POS);

    logic src_hit;
    assign src_hit = |(sts & en & SRC_ONLY);
    assign irq     = en[MASTER_POS] & src_hit;

endmodule

// File: rtl/usbh_irq_bank.sv
module usbh_irq_bank
    import irq_bank_pkg::*;
#(
    parameter int unsigned ADDR_W   = 8,
    parameter int unsigned OFS_STS  = 'h00,
    parameter int unsigned OFS_ENA  = 'h04,
    parameter int unsigned OFS_DIS  = 'h08,
    parameter word_t       EVT_MASK = EVT_SRC_MASK
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    input  logic [31:0]       hw_evt,
    output logic              irq
);

    localparam word_t EN_MASK = EVT_MASK | (word_t'(1) << MASTER_POS);

    bus_req_t req;
    word_t    sts_q;
    word_t    en_q;

    irq_bank_decode #(
        .ADDR_W (ADDR_W),
        .OFS_STS(OFS_STS),
        .OFS_ENA(OFS_ENA),
        .OFS_DIS(OFS_DIS)
    ) u_dec (
        .addr (bus_addr),
        .wr   (bus_wr),
        .wdata(bus_wdata),
        .req  (req)
    );

    irq_bank_status #(.EVT_MASK(EVT_MASK)) u_sts (
        .clk  (clk),
        .rst  (rst),
        .req  (req),
        .evt  (hw_evt),
        .sts_q(sts_q)
    );

    irq_bank_enable #(.EN_MASK(EN_MASK)) u_en (
        .clk (clk),
        .rst (rst),
        .req (req),
        .en_q(en_q)
    );

    irq_bank_combine u_cmb (
        .sts(sts_q),
        .en (en_q),
        .irq(irq)
    );

    always_comb begin
        case (req.sel)
            SEL_STS:          bus_rdata = sts_q;
            SEL_ENA, SEL_DIS: bus_rdata = en_q;
            default:          bus_rdata = '0;
        endcase
    end

endmodule

// File: rtl/irq_bank_chk.sv
module irq_bank_chk
    import irq_bank_pkg::*;
#(
    parameter int unsigned ADDR_W   = 8,
    parameter int unsigned OFS_STS  = 'h00,
    parameter int unsigned OFS_ENA  = 'h04,
    parameter int unsigned OFS_DIS  = 'h08,
    parameter word_t       EVT_MASK = EVT_SRC_MASK
) (
    input logic              clk,
    input logic              rst,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_wr,
    input logic [31:0]       bus_wdata,
    input logic [31:0]       hw_evt,
    input logic [31:0]       sts_q,
    input logic [31:0]       en_q,
    input logic              irq
);

    localparam word_t EN_MASK = EVT_MASK | (word_t'(1) << MASTER_POS);

    logic wr_sts, wr_ena, wr_dis;
    assign wr_sts = bus_wr && (bus_addr == ADDR_W'(OFS_STS));
    assign wr_ena = bus_wr && (bus_addr == ADDR_W'(OFS_ENA));
    assign wr_dis = bus_wr && (bus_addr == ADDR_W'(OFS_DIS));

    // R1: reset empties both registers
    p_reset_empty_r1: assert property (@(posedge clk)
        rst |=> (sts_q == '0) && (en_q == '0));

    // R2, R4: a strobed source is set one edge later, even under a clear
    p_evt_sets_r2: assert property (@(posedge clk) disable iff (rst)
        ((hw_evt & EVT_MASK) != '0) |=>
        ((sts_q & $past(hw_evt & EVT_MASK)) == $past(hw_evt & EVT_MASK)));

    // R3: acknowledged bits without a competing event are gone
    p_ack_clears_r3: assert property (@(posedge clk) disable iff (rst)
        wr_sts |=> ((sts_q & $past(bus_wdata & ~hw_evt)) == '0));

    // R5: set writes turn bits on, clear writes turn them off
    p_mask_set_r5: assert property (@(posedge clk) disable iff (rst)
        wr_ena |=> ((en_q & $past(bus_wdata & EN_MASK)) == $past(bus_wdata & EN_MASK)));

    p_mask_clr_r5: assert property (@(posedge clk) disable iff (rst)
        wr_dis |=> ((en_q & $past(bus_wdata)) == '0));

    p_mask_hold_r5: assert property (@(posedge clk) disable iff (rst)
        !(wr_ena || wr_dis) |=> $stable(en_q));

    // R9: gate low keeps the line low
    p_gate_low_r9: assert property (@(posedge clk) disable iff (rst)
        !en_q[MASTER_POS] |-> !irq);

    // R8: a raised line always has an enabled pending source behind it
    p_irq_source_r8: assert property (@(posedge clk) disable iff (rst)
        irq |-> ((sts_q & en_q) != '0));

endmodule

bind usbh_irq_bank irq_bank_chk #(
    .ADDR_W  (ADDR_W),
    .OFS_STS (OFS_STS),
    .OFS_ENA (OFS_ENA),
    .OFS_DIS (OFS_DIS),
    .EVT_MASK(EVT_MASK)
) u_chk (
    .clk      (clk),
    .rst      (rst),
    .bus_addr (bus_addr),
    .bus_wr   (bus_wr),
    .bus_wdata(bus_wdata),
    .hw_evt   (hw_evt),
    .sts_q    (sts_q),
    .en_q     (en_q),
    .irq      (irq)
);

// File: tb/usbh_irq_bank_tb_top.sv
module usbh_irq_bank_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam logic [7:0]  A_STS = 8'h00;
    localparam logic [7:0]  A_ENA = 8'h04;
    localparam logic [7:0]  A_DIS = 8'h08;
    localparam logic [31:0] SM    = 32'h4000_007F;
    localparam logic [31:0] EM    = 32'hC000_007F;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [7:0]  bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [31:0] hw_evt = '0;
    logic        irq;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    logic [31:0] m_sts = '0;
    logic [31:0] m_en  = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    usbh_irq_bank dut_i (
        .clk      (clk),
        .rst      (rst),
        .bus_addr (bus_addr),
        .bus_wr   (bus_wr),
        .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata),
        .hw_evt   (hw_evt),
        .irq      (irq)
    );

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic cyc(input logic [7:0] a, input logic w, input logic [31:0] d, input logic [31:0] e);
        @(negedge clk);
        bus_addr = a; bus_wr = w; bus_wdata = d; hw_evt = e;
        @(posedge clk);
        if (w && a == A_STS) m_sts = m_sts & ~d;
        if (w && a == A_ENA) m_en  = m_en | (d & EM);
        if (w && a == A_DIS) m_en  = m_en & ~d;
        m_sts = m_sts | (e & SM);
    endtask

    task automatic rd_chk(input logic [7:0] a, input logic [31:0] exp, input string tag);
        @(negedge clk);
        bus_addr = a; bus_wr = 1'b0; bus_wdata = '0; hw_evt = '0;
        #1;
        chk(bus_rdata === exp, tag, bus_rdata, exp);
    endtask

    function automatic logic irq_exp();
        return m_en[31] && ((m_sts & m_en & 32'h7FFF_FFFF) != 0);
    endfunction

    task automatic irq_chk(input string tag);
        @(negedge clk);
        bus_wr = 1'b0; hw_evt = '0;
        #1;
        chk(irq === irq_exp(), tag, {31'd0, irq}, {31'd0, irq_exp()});
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            bad++; total++;
            $display("FAIL watchdog act=running exp=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk) rst = 1'b0;

        // R1 reset state
        rd_chk(A_STS, 32'h0, "R1 status");
        rd_chk(A_ENA, 32'h0, "R1 mask set addr");
        rd_chk(A_DIS, 32'h0, "R1 mask clr addr");
        irq_chk("R1 irq");

        // R2, R3, R7 per-position event and acknowledge sweep
        for (int i = 0; i < 32; i++) begin
            cyc(A_STS, 1'b0, '0, 32'(1) << i);
            rd_chk(A_STS, m_sts, SM[i] ? "R2 event sets" : "R7 unimplemented event");
            cyc(A_STS, 1'b1, 32'(1) << i, '0);
            rd_chk(A_STS, m_sts, "R3 ack clears");
        end

        // R3 zero bits have no effect
        cyc(A_STS, 1'b0, '0, 32'hFFFF_FFFF);
        cyc(A_STS, 1'b1, 32'h0, '0);
        rd_chk(A_STS, SM, "R3 zero write keeps");
        cyc(A_STS, 1'b1, 32'h0000_0055, '0);
        rd_chk(A_STS, m_sts, "R3 partial ack");

        // R4 set beats clear in the same cycle
        for (int i = 0; i < 31; i++) begin
            if (SM[i]) begin
                cyc(A_STS, 1'b0, '0, SM);
                cyc(A_STS, 1'b1, 32'hFFFF_FFFF, 32'(1) << i);
                rd_chk(A_STS, 32'(1) << i, "R4 set wins");
            end
        end
        cyc(A_STS, 1'b1, 32'hFFFF_FFFF, '0);

        // R5, R6, R7 mask set and clear sweep
        for (int i = 0; i < 32; i++) begin
            cyc(A_ENA, 1'b1, 32'(1) << i, '0);
            rd_chk(A_ENA, m_en, EM[i] ? "R5 mask set" : "R7 unimplemented mask");
            rd_chk(A_DIS, m_en, "R6 clr addr mirrors");
        end
        rd_chk(A_ENA, EM, "R5 full mask");
        for (int i = 0; i < 32; i++) begin
            cyc(A_DIS, 1'b1, 32'(1) << i, '0);
            rd_chk(A_DIS, m_en, "R5 mask clear");
            rd_chk(A_ENA, m_en, "R6 set addr mirrors");
        end
        cyc(A_ENA, 1'b1, 32'hFFFF_FFFF, '0);
        cyc(A_DIS, 1'b1, 32'h0, '0);
        rd_chk(A_DIS, EM, "R5 zero clear keeps");
        cyc(A_DIS, 1'b1, 32'hFFFF_FFFF, '0);

        // R8, R9 interrupt gating per source
        for (int j = 0; j < 31; j++) begin
            if (SM[j]) begin
                for (int m = 0; m < 4; m++) begin
                    cyc(A_STS, 1'b1, 32'hFFFF_FFFF, '0);
                    cyc(A_DIS, 1'b1, 32'hFFFF_FFFF, '0);
                    cyc(A_ENA, 1'b1, (m[0] ? (32'(1) << j) : 32'h0) | (m[1] ? 32'h8000_0000 : 32'h0), '0);
                    irq_chk("R9 nothing pending");
                    cyc(A_STS, 1'b0, '0, 32'(1) << j);
                    irq_chk(m == 3 ? "R8 irq raised" : "R9 irq held low");
                end
                // other source enabled only: no interrupt
                cyc(A_DIS, 1'b1, 32'hFFFF_FFFF, '0);
                cyc(A_ENA, 1'b1, 32'h8000_0000 | (SM & ~(32'(1) << j)), '0);
                irq_chk("R9 foreign mask");
                cyc(A_STS, 1'b1, 32'(1) << j, '0);
                irq_chk("R8 ack drops irq");
            end
        end

        // R10 unmapped addresses
        cyc(A_STS, 1'b0, '0, 32'h0000_0012);
        cyc(A_ENA, 1'b1, 32'h8000_0003, '0);
        cyc(8'h0C, 1'b1, 32'hFFFF_FFFF, '0);
        cyc(8'hFC, 1'b1, 32'hFFFF_FFFF, '0);
        rd_chk(8'h0C, 32'h0, "R10 unmapped read");
        rd_chk(8'hFC, 32'h0, "R10 unmapped read high");
        rd_chk(A_STS, m_sts, "R10 status untouched");
        rd_chk(A_ENA, m_en, "R10 mask untouched");

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule